// File: doc/BRIEF.md
# Compare-Channel Timer with Watchdog Reset

This block is a memory-mapped timer. A free-running up-counter advances once per microsecond, on a tick enable that a prescaler derives from the input clock. Six compare channels each hold an absolute target value. When the counter steps onto a channel's target, that channel's sticky status bit is set. If the channel's interrupt enable is also set, its interrupt line is raised.

Channel 5 doubles as the system watchdog. Software arms it by setting the global watchdog enable and the channel-5 interrupt enable. It then writes, to the channel-5 target, a snapshot of the counter plus the timeout in ticks. The snapshot is taken through a latch register so that it is coherent. Software must rewrite the target before the counter reaches it. If the counter gets there first, the block emits a fixed-length reset pulse. The time remaining is always the channel-5 target minus the current counter, taken modulo the counter width.

The register port is single-cycle. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `mct_timer`

## Requirements
- R1: The counter (CNT_W bits, default 32) advances by exactly one every CLK_DIV clock cycles and reads at offset 0x00; it is not writable.
- R2: A write to offset 0x30 with bit 0 set copies the counter into the snapshot register at 0x34. The snapshot holds until the next such write. A write to 0x30 with bit 0 clear leaves the snapshot unchanged.
- R3: The target of channel i (i = 0..5) is read and written at offset 0x08 + 4*i. Only the low CNT_W bits are stored. Channel 5 (offset 0x1C) is the watchdog channel.
- R4: A channel's status bit (bit i of offset 0x20) is set in the cycle the counter steps onto that channel's target. Equality is tested on CNT_W bits, so a target that lies past the counter's wrap point still matches.
- R5: Writing 1 to a bit of the status register at 0x20 clears that bit. Writing 0 to a bit leaves it as it is.
- R6: Output irq[i] is high exactly while status bit i and interrupt enable bit i (bit i of offset 0x24) are both set.
- R7: A channel-5 match produces a reset pulse only when the watchdog enable (bit 0 of offset 0x28) and interrupt enable bit 5 are both set. Otherwise the match produces no pulse.
- R8: The reset output wdt_rst is high for exactly RST_LEN cycles per watchdog match. The pulse starts in the cycle the counter shows the target value. No further pulse follows until the channel-5 target is written again.
- R9: After reset, all registers read zero and no output is high. Unmapped offsets (for example 0x04, 0x3C) and the latch trigger at 0x30 read zero. The enable register at 0x28 keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| irq | output | NCH | Per-channel interrupt lines |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
On every cycle the assertions check four things. The counter changes only after a tick, and only by one. A status bit rises only in the cycle after its channel's match event. Every reset pulse follows a channel-5 match that had both enables set. Every pulse lasts exactly RST_LEN cycles. Some behaviours need whole software sequences, so only the bench's scenarios can show them: the snapshot's coherence with the live counter, write-one-to-clear, the silence of a match when one enable is missing, the match across the counter's wrap point, and the absence of a second pulse until the target is rewritten.

// File: rtl/mct_pkg.sv
package mct_pkg;
  // Byte offsets seen by software
  localparam logic [7:0] OFS_COUNT   = 8'h00;
  localparam logic [7:0] OFS_MATCH0  = 8'h08;
  localparam logic [7:0] OFS_STATUS  = 8'h20;
  localparam logic [7:0] OFS_IRQ_EN  = 8'h24;
  localparam logic [7:0] OFS_WD_EN   = 8'h28;
  localparam logic [7:0] OFS_LATCH   = 8'h30;
  localparam logic [7:0] OFS_SNAP    = 8'h34;

  // Offset of the target register of channel idx
  function automatic logic [7:0] target_offset(input int idx);
    return OFS_MATCH0 + 8'(4 * idx);
  endfunction
endpackage

// File: rtl/mct_tick_gen.sv
module mct_tick_gen #(
  parameter int CLK_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(CLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/mct_channels.sv
module mct_channels #(
  parameter int NCH   = 6,
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CNT_W-1:0]   cnt_nxt,
  input  logic [NCH*CNT_W-1:0] target_flat,
  input  logic [NCH-1:0]     clr,
  output logic [NCH-1:0]     hit,
  output logic [NCH-1:0]     status_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // event: counter is stepping onto this channel's target
    assign hit[i] = tick && (cnt_nxt == target_flat[i*CNT_W +: CNT_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status_q[i] <= 1'b0;
      else if (hit[i]) status_q[i] <= 1'b1;
      else if (clr[i]) status_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mct_rst_pulse.sv
module mct_rst_pulse #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int LW = $clog2(RST_LEN + 1);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (fire)         left_q <= LW'(RST_LEN - 1);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 1'b0;
    else if (fire) run_q <= 1'b1;
    else if (left_q == '0) run_q <= 1'b0;
  end

  assign pulse = run_q;
endmodule

// File: rtl/mct_timer.sv
module mct_timer #(
  parameter int CLK_DIV = 125,
  parameter int CNT_W   = 32,
  parameter int NCH     = 6,
  parameter int WDT_CH  = 5,
  parameter int RST_LEN = 16,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] irq,
  output logic          wdt_rst
);
  import mct_pkg::*;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic en);
    return en ? c + 1'b1 : c;
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic [7:0] ofs);
    return AW'(ofs);
  endfunction

  // ---------------- tick and counter ----------------
  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  mct_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  assign cnt_nxt = step_count(cnt_q, tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // ---------------- register writes ----------------
  logic wr_en;
  assign wr_en = bus_sel && bus_wr;

  logic [NCH*CNT_W-1:0] target_flat;
  logic [NCH-1:0]       tgt_wr;

  for (genvar i = 0; i < NCH; i++) begin : g_tgt
    assign tgt_wr[i] = wr_en && (bus_addr == addr_of(target_offset(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         target_flat[i*CNT_W +: CNT_W] <= '0;
      else if (tgt_wr[i]) target_flat[i*CNT_W +: CNT_W] <= bus_wdata[CNT_W-1:0];
    end
  end

  logic [NCH-1:0]   ie_q;
  logic             wden_q;
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      wden_q <= 1'b0;
      snap_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == addr_of(OFS_IRQ_EN)) ie_q   <= bus_wdata[NCH-1:0];
      if (bus_addr == addr_of(OFS_WD_EN))  wden_q <= bus_wdata[0];
      if (bus_addr == addr_of(OFS_LATCH) && bus_wdata[0]) snap_q <= cnt_q;
    end
  end

  logic [NCH-1:0] status_clr;
  assign status_clr = (wr_en && bus_addr == addr_of(OFS_STATUS)) ?
                      bus_wdata[NCH-1:0] : '0;

  // ---------------- compare channels ----------------
  logic [NCH-1:0] hit, status_q;

  mct_channels #(.NCH(NCH), .CNT_W(CNT_W)) u_ch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_nxt(cnt_nxt),
    .target_flat(target_flat), .clr(status_clr),
    .hit(hit), .status_q(status_q));

  assign irq = status_q & ie_q;

  // ---------------- watchdog ----------------
  logic spent_q;   // set once the watchdog target has fired
  logic fire_evt;

  assign fire_evt = hit[WDT_CH] && ie_q[WDT_CH] && wden_q && !spent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              spent_q <= 1'b0;
    else if (tgt_wr[WDT_CH]) spent_q <= 1'b0;
    else if (fire_evt)       spent_q <= 1'b1;
  end

  mct_rst_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire_evt), .pulse(wdt_rst));

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == addr_of(OFS_COUNT))  bus_rdata = DW'(cnt_q);
    if (bus_addr == addr_of(OFS_STATUS)) bus_rdata = DW'(status_q);
    if (bus_addr == addr_of(OFS_IRQ_EN)) bus_rdata = DW'(ie_q);
    if (bus_addr == addr_of(OFS_WD_EN))  bus_rdata = DW'(wden_q);
    if (bus_addr == addr_of(OFS_SNAP))   bus_rdata = DW'(snap_q);
    for (int i = 0; i < NCH; i++)
      if (bus_addr == addr_of(target_offset(i)))
        bus_rdata = DW'(target_flat[i*CNT_W +: CNT_W]);
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int NCH     = 6,
  parameter int WDT_CH  = 5,
  parameter int RST_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [NCH-1:0]   hit,
  input logic [NCH-1:0]   status_q,
  input logic [NCH-1:0]   ie_q,
  input logic             wden_q,
  input logic             fire_evt,
  input logic             wdt_rst
);
  int hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= 0;
    else if (wdt_rst) hi_len <= hi_len + 1;
    else              hi_len <= 0;
  end

  // R1: counter only moves after a tick, and only by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ($past(tick) && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R4: a status bit rises only after its channel's match event
  a_r4_status_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(hit)) == '0));

  // R7: a reset pulse starts only after a gated watchdog match
  a_r7_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(hit[WDT_CH] && wden_q && ie_q[WDT_CH]));

  // R8: a firing raises the reset in the next cycle
  a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> wdt_rst);

  // R8: each pulse lasts exactly RST_LEN cycles
  a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (hi_len == RST_LEN));
endmodule

bind mct_timer mct_timer_chk #(
  .CNT_W(CNT_W), .NCH(NCH), .WDT_CH(WDT_CH), .RST_LEN(RST_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .hit(hit),
  .status_q(status_q), .ie_q(ie_q), .wden_q(wden_q),
  .fire_evt(fire_evt), .wdt_rst(wdt_rst)
);

// File: tb/sim_mct_timer.sv
module sim_mct_timer;
  localparam int CLK_DIV = 3;
  localparam int CNT_W   = 8;
  localparam int NCH     = 6;
  localparam int RST_LEN = 5;
  localparam logic [31:0] CMASK = 32'hFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;
  logic        wdt_rst;

  always #4 clk = ~clk;   // 125 MHz

  mct_timer #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W), .NCH(NCH), .WDT_CH(5),
              .RST_LEN(RST_LEN), .AW(8), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdt_rst(wdt_rst));

  int n_chk = 0, n_bad = 0;
  int n_pulse = 0, n_hi = 0;
  logic prev_rst = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wdt_rst) n_hi++;
      if (wdt_rst && !prev_rst) n_pulse++;
    end
    prev_rst = wdt_rst;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n * CLK_DIV) @(negedge clk);
  endtask

  typedef struct packed {
    logic        w;
    logic [7:0]  a;
    logic [31:0] d;
  } vec_t;

  // register access table: writes carry data, reads carry the expected value
  localparam vec_t VEC [14] = '{
    '{1'b1, 8'h08, 32'hFFFF_FF5A},  // R3 target 0, masked to CNT_W
    '{1'b0, 8'h08, 32'h0000_005A},
    '{1'b1, 8'h14, 32'h0000_0133},  // R3 target 3
    '{1'b0, 8'h14, 32'h0000_0033},
    '{1'b0, 8'h1C, 32'h0000_0000},  // R3 untouched channel 5
    '{1'b1, 8'h24, 32'hFFFF_FFC3},  // R6 only six enable bits
    '{1'b0, 8'h24, 32'h0000_0003},
    '{1'b1, 8'h28, 32'hFFFF_FFFE},  // R9 only bit 0 kept
    '{1'b0, 8'h28, 32'h0000_0000},
    '{1'b0, 8'h04, 32'h0000_0000},  // R9 unmapped
    '{1'b0, 8'h3C, 32'h0000_0000},  // R9 unmapped
    '{1'b0, 8'h30, 32'h0000_0000},  // R9 latch trigger reads zero
    '{1'b1, 8'h24, 32'h0000_0000},
    '{1'b0, 8'h24, 32'h0000_0000}
  };

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c0, c1, snap, tgt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    check("R9 wdt_rst", {31'b0, wdt_rst}, 32'h0);
    check("R9 irq", {26'b0, irq}, 32'h0);
    rd(8'h20, v); check("R9 status", v, 32'h0);
    rd(8'h24, v); check("R9 irq_en", v, 32'h0);
    rd(8'h28, v); check("R9 wd_en", v, 32'h0);
    rd(8'h34, v); check("R9 snapshot", v, 32'h0);

    // table walk (R3, R6, R9)
    foreach (VEC[k]) begin
      if (VEC[k].w) wr(VEC[k].a, VEC[k].d);
      else begin
        rd(VEC[k].a, v);
        check($sformatf("R3/R9 table %0d", k), v, VEC[k].d);
      end
    end

    // R1: exact tick rate
    rd(8'h00, c0);
    repeat (10 * CLK_DIV - 1) @(negedge clk);
    rd(8'h00, c1);
    check("R1 count rate", (c1 - c0) & CMASK, 32'd10);

    // R2: coherent snapshot
    wr(8'h30, 32'h1);
    rd(8'h34, snap);
    rd(8'h00, c0);
    check("R2 snapshot near count", {31'b0, ((c0 - snap) & CMASK) <= 1}, 32'h1);
    ticks(10);
    rd(8'h34, v); check("R2 snapshot held", v, snap);
    wr(8'h30, 32'h0);
    rd(8'h34, v); check("R2 bit0 clear no copy", v, snap);

    // R4, R6, R5: plain channels
    wr(8'h20, 32'h3F);
    wr(8'h24, 32'h04);
    wr(8'h30, 32'h1);
    rd(8'h34, snap);
    wr(8'h0C, (snap + 6) & CMASK);
    wr(8'h10, (snap + 6) & CMASK);
    ticks(9);
    rd(8'h20, v); check("R4 status set", v & 32'h06, 32'h06);
    check("R6 irq follows enable", {26'b0, irq} & 32'h06, 32'h04);
    wr(8'h20, 32'h04);
    rd(8'h20, v); check("R5 w1c clears only bit2", v & 32'h06, 32'h02);
    check("R6 irq drops", {31'b0, irq[2]}, 32'h0);

    // R7: watchdog enable clear, channel enable set
    wr(8'h20, 32'h3F);
    wr(8'h24, 32'h20);
    wr(8'h28, 32'h0);
    wr(8'h30, 32'h1);
    rd(8'h34, snap);
    wr(8'h1C, (snap + 6) & CMASK);
    ticks(9);
    check("R7 no pulse without wd_en", n_pulse, 0);
    rd(8'h20, v); check("R7 status5 set", v & 32'h20, 32'h20);
    check("R6 irq5 set", {31'b0, irq[5]}, 32'h1);

    // R7: watchdog enable set, channel enable clear
    wr(8'h20, 32'h3F);
    wr(8'h24, 32'h00);
    wr(8'h28, 32'h1);
    wr(8'h30, 32'h1);
    rd(8'h34, snap);
    wr(8'h1C, (snap + 6) & CMASK);
    ticks(9);
    check("R7 no pulse without ie5", n_pulse, 0);
    rd(8'h20, v); check("R7 status5 set again", v & 32'h20, 32'h20);

    // R8 + R4 wrap: full watchdog with target past wrap point
    wr(8'h20, 32'h3F);
    wr(8'h24, 32'h20);
    wr(8'h28, 32'h1);
    v = 0;
    while (v < 240 || v > 250) rd(8'h00, v);
    wr(8'h30, 32'h1);
    rd(8'h34, snap);
    tgt = (snap + 20) & CMASK;
    wr(8'h1C, tgt);
    rd(8'h00, c0);
    v = (tgt - c0) & CMASK;
    check("R8 time left window", {31'b0, (v >= 16 && v <= 20)}, 32'h1);
    ticks(14);
    check("R8 no early pulse", n_pulse, 0);
    ticks(10);
    check("R8 one pulse", n_pulse, 1);
    check("R8 pulse length", n_hi, RST_LEN);
    rd(8'h20, v); check("R4 wrap match", v & 32'h20, 32'h20);

    // R8: no retrigger on the next lap
    ticks(260);
    check("R8 no retrigger", n_pulse, 1);
    wr(8'h1C, tgt);
    ticks(260);
    check("R8 rearm fires again", n_pulse, 2);
    check("R8 second pulse length", n_hi, 2 * RST_LEN);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule